// File: doc/BRIEF.md
# Load Collision Predictor

This block guesses, before a load is scheduled, whether that load will hit the address of an older store that has not yet executed. The scheduler presents the load's instruction pointer. One cycle later the block returns a colliding or non-colliding verdict. When the verdict comes from the tagged table, it also returns a store count that the load may safely pass. A non-colliding load may issue ahead of every older store. A colliding load waits, either for all older stores or for all but the number of stores given in the distance.

Two tables work together. A small set-associative table holds tags of loads that have collided, and a tag match there always means colliding. A larger direct-mapped table, indexed by low pointer bits and without tags, holds one bit per slot that follows the most recent outcome. Both tables are trained when a load retires, from the verdict it received and whether it actually collided. A clear input wipes both tables, so loads whose behaviour has changed can lose the colliding mark.

Top module: `lsc_predictor`

## Requirements
- R1: While reset is asserted, and on the first lookup after reset, `pr_valid` is 0 during reset and the verdict is non-colliding with `pr_dist_valid` = 0.
- R2: A cycle with `lk_valid` = 0 gives `pr_valid` = 0 in the next cycle. Every result appears exactly one cycle after its lookup.
- R3: A lookup that misses the tagged table and finds a 0 in the tagless slot gives `pr_collide` = 0 and `pr_dist_valid` = 0.
- R4: A retire with `rt_pred_collide` = 0 and `rt_act_collide` = 1 places the pointer in the tagged table with distance `rt_dist`. Later lookups of that pointer give `pr_collide` = 1, `pr_dist_valid` = 1 and that distance. `pr_dist_valid` = 1 only ever comes with `pr_collide` = 1.
- R5: A resident tagged entry is sticky. A retire with `rt_act_collide` = 0 never makes its lookup non-colliding.
- R6: Every retire writes `rt_act_collide` into the tagless slot `rt_ip[5:0]`. A tagless 1 without a tagged hit gives `pr_collide` = 1 and `pr_dist_valid` = 0.
- R7: A colliding retire that hits a tagged entry stores the minimum of the old distance and `rt_dist`.
- R8: A retire with `rt_pred_collide` = 1 never creates a tagged entry.
- R9: The tagged table has 16 sets (set = `ip[3:0]`, tag = `ip[31:4]`) of 4 ways. A new entry goes into the way named by a per-set round-robin pointer, so the fifth distinct load in a set evicts the first one placed.
- R10: A lookup in the same cycle as a retire update to the same entry sees the updated contents.
- R11: `clr` empties the tagged table and zeroes every tagless bit in one cycle. It overrides a retire update in the same cycle, and a lookup in that cycle sees the cleared state.
- R12: Loads whose pointers share bits [5:0] share one tagless slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Wipe both tables |
| lk_valid | input | 1 | Lookup request |
| lk_ip | input | IP_W | Pointer of the load being looked up |
| rt_valid | input | 1 | Retire training request |
| rt_ip | input | IP_W | Pointer of the retiring load |
| rt_pred_collide | input | 1 | Verdict that load was given |
| rt_act_collide | input | 1 | Whether it really collided |
| rt_dist | input | DIST_W | Store distance of the observed collision |
| pr_valid | output | 1 | Result valid, one cycle after lookup |
| pr_collide | output | 1 | 1 = colliding verdict |
| pr_dist_valid | output | 1 | Distance field is meaningful |
| pr_dist | output | DIST_W | Stores the load may pass |

## Verification
The hardest state to reach from the ports is a full set followed by an eviction under the round-robin pointer. This is only visible indirectly, because an evicted load may still read as colliding through its tagless slot. The stimulus fills set 2 with four loads that share a tagless slot and adds a fifth. It then shows that the first load has lost its distance but still reads as colliding, while the later loads keep theirs. Same-cycle collisions between a retire and a lookup, and between a retire and `clr`, are driven directly as rows of the vector table.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  // what a retire did to the tagged table
  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_ALLOC  = 2'd1,
    UPD_SHRINK = 2'd2
  } upd_kind_e;

  localparam int unsigned DEF_IP_W   = 32;
  localparam int unsigned DEF_SETS   = 16;
  localparam int unsigned DEF_WAYS   = 4;
  localparam int unsigned DEF_TL_ENT = 64;
  localparam int unsigned DEF_DIST_W = 4;
endpackage

// File: rtl/lsc_tag_table.sv
module lsc_tag_table
  import lsc_pkg::*;
#(
  parameter int unsigned IP_W   = DEF_IP_W,
  parameter int unsigned SETS   = DEF_SETS,
  parameter int unsigned WAYS   = DEF_WAYS,
  parameter int unsigned DIST_W = DEF_DIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd_v,
  input  logic [IP_W-1:0]   upd_ip,
  input  logic              upd_pred,
  input  logic              upd_act,
  input  logic [DIST_W-1:0] upd_dist,
  input  logic [IP_W-1:0]   lk_ip,
  output logic              lk_hit,
  output logic [DIST_W-1:0] lk_dist,
  output logic [WAYS-1:0]   lk_hit_vec,
  output upd_kind_e         upd_kind
);
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned TAG_W = IP_W - SET_W;

  function automatic logic [DIST_W-1:0] dist_min(input logic [DIST_W-1:0] a,
                                                 input logic [DIST_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [WAY_W-1:0] way_next(input logic [WAY_W-1:0] w);
    return (w == WAY_W'(WAYS - 1)) ? '0 : w + 1'b1;
  endfunction

  function automatic logic [WAY_W-1:0] first_way(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (v[w]) r = WAY_W'(w);
    return r;
  endfunction

  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAYS-1:0]   vld_d  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_d  [SETS][WAYS];
  logic [DIST_W-1:0] dist_q [SETS][WAYS];
  logic [DIST_W-1:0] dist_d [SETS][WAYS];
  logic [WAY_W-1:0]  rr_q   [SETS];
  logic [WAY_W-1:0]  rr_d   [SETS];

  logic [SET_W-1:0] u_set, l_set;
  logic [TAG_W-1:0] u_tag, l_tag;
  logic [WAYS-1:0]  u_hit_vec;
  logic [WAY_W-1:0] u_way, a_way;

  assign u_set = upd_ip[SET_W-1:0];
  assign u_tag = upd_ip[IP_W-1:SET_W];
  assign l_set = lk_ip[SET_W-1:0];
  assign l_tag = lk_ip[IP_W-1:SET_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      u_hit_vec[w] = vld_q[u_set][w] && (tag_q[u_set][w] == u_tag);
  end
  assign u_way = first_way(u_hit_vec);
  assign a_way = rr_q[u_set];

  // classify the retire event
  always_comb begin
    upd_kind = UPD_NONE;
    if (upd_v && !clr && upd_act) begin
      if (|u_hit_vec)     upd_kind = UPD_SHRINK;
      else if (!upd_pred) upd_kind = UPD_ALLOC;
    end
  end

  // next state of the table; lookups read it (write-first)
  always_comb begin
    vld_d  = vld_q;
    tag_d  = tag_q;
    dist_d = dist_q;
    rr_d   = rr_q;
    if (clr) begin
      for (int s = 0; s < SETS; s++) begin
        vld_d[s] = '0;
        rr_d[s]  = '0;
      end
    end else begin
      case (upd_kind)
        UPD_SHRINK: dist_d[u_set][u_way] = dist_min(dist_q[u_set][u_way], upd_dist);
        UPD_ALLOC: begin
          vld_d[u_set][a_way]  = 1'b1;
          tag_d[u_set][a_way]  = u_tag;
          dist_d[u_set][a_way] = upd_dist;
          rr_d[u_set]          = way_next(a_way);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      lk_hit_vec[w] = vld_d[l_set][w] && (tag_d[l_set][w] == l_tag);
  end
  assign lk_hit  = |lk_hit_vec;
  assign lk_dist = dist_d[l_set][first_way(lk_hit_vec)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
    tag_q  <= tag_d;
    dist_q <= dist_d;
  end
endmodule

// File: rtl/lsc_tagless_table.sv
module lsc_tagless_table
  import lsc_pkg::*;
#(
  parameter int unsigned IP_W   = DEF_IP_W,
  parameter int unsigned TL_ENT = DEF_TL_ENT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            upd_v,
  input  logic [IP_W-1:0] upd_ip,
  input  logic            upd_act,
  input  logic [IP_W-1:0] lk_ip,
  output logic            lk_bit
);
  localparam int unsigned IDX_W = (TL_ENT > 1) ? $clog2(TL_ENT) : 1;

  logic [TL_ENT-1:0] bits_q, bits_d;
  logic [IDX_W-1:0]  u_idx, l_idx;

  assign u_idx = upd_ip[IDX_W-1:0];
  assign l_idx = lk_ip[IDX_W-1:0];

  // one-bit counter: follows the last outcome
  always_comb begin
    bits_d = bits_q;
    if (clr)        bits_d = '0;
    else if (upd_v) bits_d[u_idx] = upd_act;
  end

  assign lk_bit = bits_d[l_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end
endmodule

// File: rtl/lsc_predictor.sv
module lsc_predictor
  import lsc_pkg::*;
#(
  parameter int unsigned IP_W   = DEF_IP_W,
  parameter int unsigned SETS   = DEF_SETS,
  parameter int unsigned WAYS   = DEF_WAYS,
  parameter int unsigned TL_ENT = DEF_TL_ENT,
  parameter int unsigned DIST_W = DEF_DIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              lk_valid,
  input  logic [IP_W-1:0]   lk_ip,
  input  logic              rt_valid,
  input  logic [IP_W-1:0]   rt_ip,
  input  logic              rt_pred_collide,
  input  logic              rt_act_collide,
  input  logic [DIST_W-1:0] rt_dist,
  output logic              pr_valid,
  output logic              pr_collide,
  output logic              pr_dist_valid,
  output logic [DIST_W-1:0] pr_dist
);
  logic              t_hit;
  logic [DIST_W-1:0] t_dist;
  logic [WAYS-1:0]   t_hit_vec;
  upd_kind_e         t_upd_kind;
  logic              n_bit;

  lsc_tag_table #(
    .IP_W(IP_W), .SETS(SETS), .WAYS(WAYS), .DIST_W(DIST_W)
  ) u_tag (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .upd_v(rt_valid), .upd_ip(rt_ip), .upd_pred(rt_pred_collide),
    .upd_act(rt_act_collide), .upd_dist(rt_dist),
    .lk_ip(lk_ip), .lk_hit(t_hit), .lk_dist(t_dist),
    .lk_hit_vec(t_hit_vec), .upd_kind(t_upd_kind)
  );

  lsc_tagless_table #(
    .IP_W(IP_W), .TL_ENT(TL_ENT)
  ) u_tagless (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .upd_v(rt_valid), .upd_ip(rt_ip), .upd_act(rt_act_collide),
    .lk_ip(lk_ip), .lk_bit(n_bit)
  );

  // non-colliding only when both tables agree on it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_valid      <= 1'b0;
      pr_collide    <= 1'b0;
      pr_dist_valid <= 1'b0;
      pr_dist       <= '0;
    end else begin
      pr_valid      <= lk_valid;
      pr_collide    <= lk_valid && (t_hit || n_bit);
      pr_dist_valid <= lk_valid && t_hit;
      pr_dist       <= (lk_valid && t_hit) ? t_dist : '0;
    end
  end
endmodule

// File: rtl/lsc_predictor_chk.sv
module lsc_predictor_chk
  import lsc_pkg::*;
#(
  parameter int unsigned IP_W   = DEF_IP_W,
  parameter int unsigned WAYS   = DEF_WAYS,
  parameter int unsigned DIST_W = DEF_DIST_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              lk_valid,
  input logic [IP_W-1:0]   lk_ip,
  input logic              rt_valid,
  input logic [IP_W-1:0]   rt_ip,
  input logic              rt_pred_collide,
  input logic              rt_act_collide,
  input logic [DIST_W-1:0] rt_dist,
  input logic              pr_valid,
  input logic              pr_collide,
  input logic              pr_dist_valid,
  input logic [DIST_W-1:0] pr_dist,
  input logic [WAYS-1:0]   hit_vec,
  input upd_kind_e         upd_kind
);
  // R2
  idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pr_valid);

  // R11
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && lk_valid) |=> (pr_valid && !pr_collide && !pr_dist_valid));

  // R4
  dist_needs_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_dist_valid |-> pr_collide);

  // R10
  alloc_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && rt_valid && rt_act_collide && !rt_pred_collide && lk_valid && lk_ip == rt_ip)
      |=> (pr_collide && pr_dist_valid && pr_dist == $past(rt_dist)));

  // R7
  dist_not_above_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && rt_valid && rt_act_collide && lk_valid && lk_ip == rt_ip)
      |=> (!pr_dist_valid || pr_dist <= $past(rt_dist)));

  // R6
  quiet_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && rt_valid && !rt_act_collide && lk_valid && lk_ip == rt_ip)
      |=> (pr_collide == pr_dist_valid));

  // R9
  one_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R8
  no_alloc_on_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_pred_collide) |-> (upd_kind != UPD_ALLOC));
endmodule

bind lsc_predictor lsc_predictor_chk #(
  .IP_W(IP_W), .WAYS(WAYS), .DIST_W(DIST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr),
  .lk_valid(lk_valid), .lk_ip(lk_ip),
  .rt_valid(rt_valid), .rt_ip(rt_ip), .rt_pred_collide(rt_pred_collide),
  .rt_act_collide(rt_act_collide), .rt_dist(rt_dist),
  .pr_valid(pr_valid), .pr_collide(pr_collide),
  .pr_dist_valid(pr_dist_valid), .pr_dist(pr_dist),
  .hit_vec(t_hit_vec), .upd_kind(t_upd_kind)
);

// File: tb/lsc_predictor_test.sv
module lsc_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_ip = '0;
  logic        rt_valid = 1'b0;
  logic [31:0] rt_ip = '0;
  logic        rt_pred_collide = 1'b0;
  logic        rt_act_collide = 1'b0;
  logic [3:0]  rt_dist = '0;
  logic        pr_valid, pr_collide, pr_dist_valid;
  logic [3:0]  pr_dist;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  lsc_predictor uut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .lk_valid(lk_valid), .lk_ip(lk_ip),
    .rt_valid(rt_valid), .rt_ip(rt_ip), .rt_pred_collide(rt_pred_collide),
    .rt_act_collide(rt_act_collide), .rt_dist(rt_dist),
    .pr_valid(pr_valid), .pr_collide(pr_collide),
    .pr_dist_valid(pr_dist_valid), .pr_dist(pr_dist)
  );

  typedef struct packed {
    logic        clr;
    logic        lv;
    logic [31:0] lip;
    logic        rv;
    logic [31:0] rip;
    logic        rp;
    logic        ra;
    logic [3:0]  rd;
    logic        ev;
    logic        ec;
    logic        edv;
    logic [3:0]  ed;
    logic [7:0]  req;
  } vec_t;

  localparam logic [31:0] Z  = 32'h0;
  localparam logic [31:0] A  = 32'h1000_0010;  // set 0, slot 0x10
  localparam logic [31:0] B  = 32'h2000_0021;  // set 1, slot 0x21
  localparam logic [31:0] C  = 32'h3000_0061;  // set 1, slot 0x21
  localparam logic [31:0] D1 = 32'h0000_0102;  // set 2, slot 0x02
  localparam logic [31:0] D2 = 32'h0000_0202;
  localparam logic [31:0] D3 = 32'h0000_0302;
  localparam logic [31:0] D4 = 32'h0000_0402;
  localparam logic [31:0] D5 = 32'h0000_0502;
  localparam logic [31:0] E  = 32'h0000_0033;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,A ,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b1,1'b0,1'b0,4'd0, 8'd3 },  // R3 cold miss
    '{1'b0,1'b0,Z ,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b0,1'b0,1'b0,4'd0, 8'd2 },  // R2 idle
    '{1'b0,1'b0,Z ,1'b1,A ,1'b0,1'b1,4'd9 , 1'b0,1'b0,1'b0,4'd0, 8'd4 },  // R4 train
    '{1'b0,1'b1,A ,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b1,1'b1,1'b1,4'd9, 8'd4 },  // R4 hit
    '{1'b0,1'b1,A ,1'b1,A ,1'b1,1'b1,4'd5 , 1'b1,1'b1,1'b1,4'd5, 8'd10},  // R10 bypass, R7 shrink
    '{1'b0,1'b1,A ,1'b1,A ,1'b1,1'b1,4'd12, 1'b1,1'b1,1'b1,4'd5, 8'd7 },  // R7 larger kept out
    '{1'b0,1'b1,A ,1'b1,A ,1'b1,1'b0,4'd0 , 1'b1,1'b1,1'b1,4'd5, 8'd5 },  // R5 sticky
    '{1'b0,1'b0,Z ,1'b1,B ,1'b1,1'b1,4'd3 , 1'b0,1'b0,1'b0,4'd0, 8'd8 },  // R8 no tag entry
    '{1'b0,1'b1,B ,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b1,1'b1,1'b0,4'd0, 8'd8 },  // R8 / R6 tagless only
    '{1'b0,1'b1,B ,1'b1,B ,1'b1,1'b0,4'd0 , 1'b1,1'b0,1'b0,4'd0, 8'd6 },  // R6 back to 0
    '{1'b0,1'b0,Z ,1'b1,C ,1'b1,1'b1,4'd2 , 1'b0,1'b0,1'b0,4'd0, 8'd12},  // R12 alias train
    '{1'b0,1'b1,B ,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b1,1'b1,1'b0,4'd0, 8'd12},  // R12 alias seen
    '{1'b0,1'b0,Z ,1'b1,D1,1'b0,1'b1,4'd1 , 1'b0,1'b0,1'b0,4'd0, 8'd9 },  // R9 fill
    '{1'b0,1'b0,Z ,1'b1,D2,1'b0,1'b1,4'd2 , 1'b0,1'b0,1'b0,4'd0, 8'd9 },
    '{1'b0,1'b0,Z ,1'b1,D3,1'b0,1'b1,4'd3 , 1'b0,1'b0,1'b0,4'd0, 8'd9 },
    '{1'b0,1'b0,Z ,1'b1,D4,1'b0,1'b1,4'd4 , 1'b0,1'b0,1'b0,4'd0, 8'd9 },
    '{1'b0,1'b1,D1,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b1,1'b1,1'b1,4'd1, 8'd9 },  // R9 first resident
    '{1'b0,1'b0,Z ,1'b1,D5,1'b0,1'b1,4'd5 , 1'b0,1'b0,1'b0,4'd0, 8'd9 },  // R9 fifth evicts
    '{1'b0,1'b1,D1,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b1,1'b1,1'b0,4'd0, 8'd9 },  // R9 evicted
    '{1'b0,1'b1,D5,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b1,1'b1,1'b1,4'd5, 8'd9 },
    '{1'b0,1'b1,D2,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b1,1'b1,1'b1,4'd2, 8'd9 },
    '{1'b1,1'b1,A ,1'b1,E ,1'b0,1'b1,4'd7 , 1'b1,1'b0,1'b0,4'd0, 8'd11},  // R11 clear wins
    '{1'b0,1'b1,E ,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b1,1'b0,1'b0,4'd0, 8'd11},  // R11 update dropped
    '{1'b0,1'b1,D5,1'b0,Z ,1'b0,1'b0,4'd0 , 1'b1,1'b0,1'b0,4'd0, 8'd11}   // R11 table empty
  };

  task automatic expect_out(input logic [6:0] exp, input int req, input string what);
    logic [6:0] got;
    got = {pr_valid, pr_collide, pr_dist_valid, pr_dist};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got v=%b c=%b dv=%b d=%0d, expected v=%b c=%b dv=%b d=%0d",
               req, what, got[6], got[5], got[4], got[3:0], exp[6], exp[5], exp[4], exp[3:0]);
    end
  endtask

  task automatic drive(input logic c, input logic lv, input logic [31:0] lip,
                       input logic rv, input logic [31:0] rip, input logic rp,
                       input logic ra, input logic [3:0] rd);
    clr = c; lk_valid = lv; lk_ip = lip;
    rt_valid = rv; rt_ip = rip; rt_pred_collide = rp; rt_act_collide = ra; rt_dist = rd;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, got no end, expected end");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_out(7'b0, 1, "R1 outputs held in reset");
    rst_n = 1'b1;
    drive(1'b0, 1'b1, D3, 1'b0, Z, 1'b0, 1'b0, 4'd0);
    @(negedge clk);
    expect_out({1'b1, 1'b0, 1'b0, 4'd0}, 1, "R1 first lookup after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].clr, VECS[i].lv, VECS[i].lip, VECS[i].rv, VECS[i].rip,
            VECS[i].rp, VECS[i].ra, VECS[i].rd);
      @(negedge clk);
      expect_out({VECS[i].ev, VECS[i].ec, VECS[i].edv, VECS[i].ed}, int'(VECS[i].req),
                 $sformatf("vector %0d", i));
    end

    // R4 fresh training after clear, then reset must forget it (R1)
    drive(1'b0, 1'b0, Z, 1'b1, A, 1'b0, 1'b1, 4'd3);
    @(negedge clk);
    drive(1'b0, 1'b1, A, 1'b0, Z, 1'b0, 1'b0, 4'd0);
    @(negedge clk);
    expect_out({1'b1, 1'b1, 1'b1, 4'd3}, 4, "R4 retrain after clear");
    drive(1'b0, 1'b0, Z, 1'b0, Z, 1'b0, 1'b0, 4'd0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    expect_out(7'b0, 1, "R1 outputs during second reset");
    rst_n = 1'b1;
    drive(1'b0, 1'b1, A, 1'b0, Z, 1'b0, 1'b0, 4'd0);
    @(negedge clk);
    expect_out({1'b1, 1'b0, 1'b0, 4'd0}, 1, "R1 tables empty after reset");
    drive(1'b0, 1'b0, Z, 1'b0, Z, 1'b0, 1'b0, 4'd0);
    @(negedge clk);
    expect_out(7'b0, 2, "R2 idle after lookup");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule